// File: doc/BRIEF.md
# Duplicate-Tag Coherence Snoop Filter

This block keeps a shadow copy of the L1 data cache tags of two processor cores, with one 4-way set-associative tag bank per core. Each entry holds a tag and a MESI state. The cores report every allocate, evict and state change through their own update port, and the block writes the change into its shadow copy. A coherent request from either core or from the external accelerator port is answered from the shadow copy alone. The answer says which cores must be snooped and what state each core holds the line in. The cores themselves are never stalled or queried for a lookup that misses.

A lookup is offered with a valid/ready handshake. The result appears one cycle after it is accepted. When a lookup hits in another core, the block also applies the coherence outcome to its own copy in that same cycle. A write request invalidates the other holders. A read request downgrades a Modified or Exclusive holder to Shared and flags that the data must come from that core. Core updates always win over lookups. A lookup to a set that is being updated in the same cycle is held back for one cycle, so it sees the new contents.

Top module: `snoop_filter`

## Requirements
- R1: After reset every entry of both banks is Invalid. No result is valid, and `lk_ready` is 1 while no update is offered.
- R2: An update with core c's `upd_valid` bit set writes the tag and state (encoding I=0, S=1, E=2, M=3) into core c's bank at the given set and way. Later lookups report that state. Writing state I removes the line.
- R3: An accepted lookup reports each core's directory state in `rs_state` (core c at bits 2c+1:2c; I when the tag is absent or its entry is Invalid). Bit c of `rs_snoop` is set only when core c holds the line in a valid state, so a miss in both banks gives a zero snoop vector.
- R4: `lk_src` gives the origin: 0 is core 0, 1 is core 1, 2 or 3 is the accelerator port. A lookup never sets the snoop bit of its own source core. An accelerator lookup may select both cores.
- R5: A write lookup (`lk_write`=1) that hits in a non-requesting core sets that core's snoop bit and raises `rs_inval`. It moves that core's entry to Invalid. When the entry was Modified, it also raises `rs_intervene`.
- R6: A read lookup that hits Modified or Exclusive in a non-requesting core raises `rs_intervene` and moves that entry to Shared.
- R7: A read lookup that hits only Shared lines raises neither flag and changes no entry.
- R8: `lk_ready` is 0 exactly when an update in the same cycle targets the set in `lk_set`. An update to another set does not stall a lookup.
- R9: `rs_valid` is 1 in exactly the cycle after a lookup handshake (`lk_valid` and `lk_ready` both 1), and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 2 | Per-core update strobe |
| upd_set | input | 2*log2(SETS) | Per-core set index, core c in slice c |
| upd_way | input | 4 | Per-core way, 2 bits each |
| upd_tag | input | 2*TAG_W | Per-core tag |
| upd_state | input | 4 | Per-core new state, 2 bits each |
| lk_valid | input | 1 | Lookup offered |
| lk_ready | output | 1 | Lookup can be taken this cycle |
| lk_src | input | 2 | Lookup origin: 0, 1 core; 2, 3 accelerator |
| lk_write | input | 1 | Write/exclusive request when 1, read when 0 |
| lk_set | input | log2(SETS) | Lookup set index |
| lk_tag | input | TAG_W | Lookup tag |
| rs_valid | output | 1 | Result valid |
| rs_snoop | output | 2 | Cores that must be snooped |
| rs_state | output | 4 | Directory state per core before the lookup |
| rs_inval | output | 1 | Invalidate issued to at least one core |
| rs_intervene | output | 1 | Data must come from a snooped core |

## Verification
An update written on an edge is visible to a lookup accepted on the next edge or later. `lk_ready` is combinational, so it is judged in the same cycle the update and the lookup are presented. Every result field is due at the first edge after the handshake. A coherence state change made by one lookup shows up in the result of the next accepted lookup. The bench drives inputs just after the falling edge and reads `lk_ready` a moment later. It then steps its behavioural model at the rising edge and compares every result port at the following falling edge, so each expected value lines up with the one register between request and result.

// File: rtl/snf_pkg.sv
package snf_pkg;
    localparam int NCORE = 2;
    localparam int NWAY  = 4;
    localparam int WAY_W = $clog2(NWAY);

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;
endpackage

// File: rtl/snf_way_match.sv
module snf_way_match
    import snf_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic [NWAY-1:0][TAG_W-1:0] way_tag,
    input  mesi_e [NWAY-1:0]           way_st,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output mesi_e                      hit_st
);
    logic [NWAY-1:0] hv;

    for (genvar w = 0; w < NWAY; w++) begin : g_cmp
        assign hv[w] = (way_st[w] != ST_I) && (way_tag[w] == probe_tag);
    end

    always_comb begin
        hit     = |hv;
        hit_way = '0;
        hit_st  = ST_I;
        for (int w = 0; w < NWAY; w++) begin
            if (hv[w]) begin
                hit_way = WAY_W'(w);
                hit_st  = way_st[w];
            end
        end
    end
endmodule

// File: rtl/snf_tag_bank.sv
module snf_tag_bank
    import snf_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int TAG_W = 12,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic [TAG_W-1:0] upd_tag,
    input  mesi_e            upd_st,
    input  logic             mod_en,
    input  logic [SET_W-1:0] mod_set,
    input  logic [WAY_W-1:0] mod_way,
    input  mesi_e            mod_st,
    input  logic [SET_W-1:0] rd_set,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output mesi_e            hit_st
);
    typedef struct packed {
        logic [SETS-1:0][NWAY-1:0][TAG_W-1:0] tag;
        mesi_e [SETS-1:0][NWAY-1:0]           st;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (mod_en) begin
            bank_d.st[mod_set][mod_way] = mod_st;
        end
        if (upd_en) begin
            bank_d.tag[upd_set][upd_way] = upd_tag;
            bank_d.st[upd_set][upd_way]  = upd_st;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    snf_way_match #(.TAG_W(TAG_W)) u_match (
        .way_tag   (bank_q.tag[rd_set]),
        .way_st    (bank_q.st[rd_set]),
        .probe_tag (rd_tag),
        .hit       (hit),
        .hit_way   (hit_way),
        .hit_st    (hit_st)
    );

    // R2: a core update lands in the bank even when a lookup modifies the same bank
    p_update_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> bank_q.st[$past(upd_set)][$past(upd_way)] == $past(upd_st));
endmodule

// File: rtl/snoop_filter.sv
module snoop_filter
    import snf_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int TAG_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 upd_valid,
    input  logic [2*$clog2(SETS)-1:0]  upd_set,
    input  logic [3:0]                 upd_way,
    input  logic [2*TAG_W-1:0]         upd_tag,
    input  logic [3:0]                 upd_state,
    input  logic                       lk_valid,
    output logic                       lk_ready,
    input  logic [1:0]                 lk_src,
    input  logic                       lk_write,
    input  logic [$clog2(SETS)-1:0]    lk_set,
    input  logic [TAG_W-1:0]           lk_tag,
    output logic                       rs_valid,
    output logic [1:0]                 rs_snoop,
    output logic [3:0]                 rs_state,
    output logic                       rs_inval,
    output logic                       rs_intervene
);
    localparam int SET_W = $clog2(SETS);

    typedef struct packed {
        logic             vld;
        logic [NCORE-1:0] snoop;
        logic [3:0]       st;
        logic             inval;
        logic             interv;
        logic [1:0]       src;
        logic             wr;
    } res_t;

    res_t res_d, res_q;

    logic [NCORE-1:0][SET_W-1:0] us;
    logic [NCORE-1:0][WAY_W-1:0] uw;
    logic [NCORE-1:0][TAG_W-1:0] ut;
    logic [NCORE-1:0]            hit;
    logic [NCORE-1:0][WAY_W-1:0] hway;
    mesi_e [NCORE-1:0]           hst;
    logic [NCORE-1:0]            mod_en;
    mesi_e [NCORE-1:0]           mod_st;
    logic [NCORE-1:0]            set_clash;
    logic                        accept;

    assign us = upd_set;
    assign uw = upd_way;
    assign ut = upd_tag;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        assign set_clash[c] = upd_valid[c] && (us[c] == lk_set);

        snf_tag_bank #(.SETS(SETS), .TAG_W(TAG_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_en  (upd_valid[c]),
            .upd_set (us[c]),
            .upd_way (uw[c]),
            .upd_tag (ut[c]),
            .upd_st  (mesi_e'(upd_state[2*c+:2])),
            .mod_en  (mod_en[c]),
            .mod_set (lk_set),
            .mod_way (hway[c]),
            .mod_st  (mod_st[c]),
            .rd_set  (lk_set),
            .rd_tag  (lk_tag),
            .hit     (hit[c]),
            .hit_way (hway[c]),
            .hit_st  (hst[c])
        );
    end

    assign lk_ready = ~|set_clash;
    assign accept   = lk_valid && lk_ready;

    always_comb begin
        res_d     = '0;
        res_d.vld = accept;
        res_d.src = lk_src;
        res_d.wr  = lk_write;
        mod_en    = '0;
        mod_st    = {NCORE{ST_I}};
        if (accept) begin
            for (int c = 0; c < NCORE; c++) begin
                res_d.st[2*c+:2] = hst[c];
                if (hit[c] && (lk_src != 2'(c))) begin
                    res_d.snoop[c] = 1'b1;
                    if (lk_write) begin
                        mod_en[c]    = 1'b1;
                        mod_st[c]    = ST_I;
                        res_d.inval  = 1'b1;
                        if (hst[c] == ST_M) res_d.interv = 1'b1;
                    end else if (hst[c] == ST_M || hst[c] == ST_E) begin
                        mod_en[c]    = 1'b1;
                        mod_st[c]    = ST_S;
                        res_d.interv = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign rs_valid     = res_q.vld;
    assign rs_snoop     = res_q.snoop;
    assign rs_state     = res_q.st;
    assign rs_inval     = res_q.inval;
    assign rs_intervene = res_q.interv;

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rs_valid);
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && lk_ready) |=> !rs_valid);
    p_snoop_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> ((!rs_snoop[0] || rs_state[1:0] != 2'd0) &&
                      (!rs_snoop[1] || rs_state[3:2] != 2'd0)));
    p_no_self_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !res_q.src[1]) |-> !rs_snoop[res_q.src[0]]);
    p_inval_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rs_inval |-> (rs_valid && res_q.wr && rs_snoop != 2'b00));
    p_intervene_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rs_intervene |-> (rs_valid && rs_snoop != 2'b00));
    p_stall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_ready |-> (upd_valid != 2'b00));
endmodule

// File: tb/sim_snoop_filter.sv
module sim_snoop_filter;
    localparam int SETS  = 16;
    localparam int TAG_W = 12;
    localparam int SW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]         upd_valid = '0;
    logic [2*SW-1:0]    upd_set = '0;
    logic [3:0]         upd_way = '0;
    logic [2*TAG_W-1:0] upd_tag = '0;
    logic [3:0]         upd_state = '0;
    logic               lk_valid = 1'b0;
    logic               lk_ready;
    logic [1:0]         lk_src = '0;
    logic               lk_write = 1'b0;
    logic [SW-1:0]      lk_set = '0;
    logic [TAG_W-1:0]   lk_tag = '0;
    logic               rs_valid;
    logic [1:0]         rs_snoop;
    logic [3:0]         rs_state;
    logic               rs_inval;
    logic               rs_intervene;

    always #4 clk = ~clk;

    snoop_filter #(.SETS(SETS), .TAG_W(TAG_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_set(upd_set), .upd_way(upd_way),
        .upd_tag(upd_tag), .upd_state(upd_state),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_src(lk_src),
        .lk_write(lk_write), .lk_set(lk_set), .lk_tag(lk_tag),
        .rs_valid(rs_valid), .rs_snoop(rs_snoop), .rs_state(rs_state),
        .rs_inval(rs_inval), .rs_intervene(rs_intervene)
    );

    int vectors = 0;
    int errors  = 0;
    int mt [2][SETS][4];
    int ms [2][SETS][4];
    bit last_acc;

    task automatic chk(input string req, input string what, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    // one clock: present inputs, check ready, step model, check registered result
    task automatic step(input bit uv0, input int us0, input int uw0, input int ut0, input int ust0,
                        input bit uv1, input int us1, input int uw1, input int ut1, input int ust1,
                        input bit lv, input int src, input bit wr, input int ls, input int lt,
                        input string req);
        int  est [2];
        bit  esn [2];
        bit  exp_rdy, exp_v, exp_inv, exp_itv;
        int  hw  [2];
        upd_valid = {uv1, uv0};
        upd_set   = {SW'(us1), SW'(us0)};
        upd_way   = {2'(uw1), 2'(uw0)};
        upd_tag   = {TAG_W'(ut1), TAG_W'(ut0)};
        upd_state = {2'(ust1), 2'(ust0)};
        lk_valid  = lv;
        lk_src    = 2'(src);
        lk_write  = wr;
        lk_set    = SW'(ls);
        lk_tag    = TAG_W'(lt);
        #1;
        exp_rdy = !((uv0 && us0 == ls) || (uv1 && us1 == ls));
        chk(req, "R8 lk_ready", int'(lk_ready), int'(exp_rdy));
        exp_v = lv && exp_rdy;
        exp_inv = 0; exp_itv = 0;
        for (int c = 0; c < 2; c++) begin
            est[c] = 0; esn[c] = 0; hw[c] = -1;
            for (int w = 0; w < 4; w++)
                if (ms[c][ls][w] != 0 && mt[c][ls][w] == lt) begin
                    est[c] = ms[c][ls][w]; hw[c] = w;
                end
        end
        if (exp_v) begin
            for (int c = 0; c < 2; c++) begin
                if (hw[c] >= 0 && src != c) begin
                    esn[c] = 1;
                    if (wr) begin
                        exp_inv = 1;
                        if (est[c] == 3) exp_itv = 1;
                        ms[c][ls][hw[c]] = 0;
                    end else if (est[c] >= 2) begin
                        exp_itv = 1;
                        ms[c][ls][hw[c]] = 1;
                    end
                end
            end
        end
        if (uv0) begin mt[0][us0][uw0] = ut0; ms[0][us0][uw0] = ust0; end
        if (uv1) begin mt[1][us1][uw1] = ut1; ms[1][us1][uw1] = ust1; end
        last_acc = exp_v;
        @(posedge clk);
        @(negedge clk);
        chk(req, "R9 rs_valid", int'(rs_valid), int'(exp_v));
        if (exp_v) begin
            chk(req, "R3 rs_state", int'(rs_state), est[1] * 4 + est[0]);
            chk(req, "R3/R4 rs_snoop", int'(rs_snoop), int'(esn[1]) * 2 + int'(esn[0]));
            chk(req, "R5 rs_inval", int'(rs_inval), int'(exp_inv));
            chk(req, "R6 rs_intervene", int'(rs_intervene), int'(exp_itv));
        end
    endtask

    task automatic upd(input int c, input int s, input int w, input int t, input int st, input string req);
        if (c == 0) step(1, s, w, t, st, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
        else        step(0, 0, 0, 0, 0, 1, s, w, t, st, 0, 0, 0, 0, 0, req);
    endtask

    task automatic look(input int src, input bit wr, input int s, input int t, input string req);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, src, wr, s, t, req);
    endtask

    task automatic idle(input string req);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < 4; w++) begin
                    mt[c][s][w] = 0; ms[c][s][w] = 0;
                end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "reset rs_valid", int'(rs_valid), 0);
        chk("R1", "reset lk_ready", int'(lk_ready), 1);
        // R1: everything invalid, tag 0 misses
        look(2, 0, 3, 0, "R1");
        // R2/R7: both cores share a line; accelerator read snoops both, no flags
        upd(0, 3, 1, 'h55, 1, "R2");
        upd(1, 3, 0, 'h55, 1, "R2");
        look(2, 0, 3, 'h55, "R7");
        // R4: core 0 read excludes itself
        look(0, 0, 3, 'h55, "R4");
        look(1, 0, 3, 'h55, "R4");
        // R6: read hits Modified in core 1, downgrade then re-check
        upd(1, 5, 3, 'ha0, 3, "R2");
        look(0, 0, 5, 'ha0, "R6");
        look(2, 0, 5, 'ha0, "R6");
        upd(0, 6, 2, 'h0b, 2, "R2");
        look(1, 0, 6, 'h0b, "R6");
        look(1, 0, 6, 'h0b, "R6");
        // R5: write hits Exclusive in core 0, then line is gone
        upd(0, 7, 0, 'h11, 2, "R2");
        look(1, 1, 7, 'h11, "R5");
        look(2, 0, 7, 'h11, "R5");
        upd(1, 8, 1, 'h22, 3, "R2");
        look(2, 1, 8, 'h22, "R5");
        // R8: same-set update stalls, retried lookup sees the new line
        step(0, 0, 0, 0, 0, 1, 9, 2, 'h33, 2, 1, 0, 0, 9, 'h33, "R8");
        look(0, 0, 9, 'h33, "R8");
        step(1, 10, 0, 'h44, 1, 0, 0, 0, 0, 0, 1, 2, 0, 9, 'h33, "R8");
        // R9: back-to-back then idle
        look(2, 0, 10, 'h44, "R9");
        look(2, 0, 10, 'h45, "R9");
        idle("R9");
        // R2: eviction via update state I, tag mismatch misses
        upd(0, 10, 0, 'h44, 0, "R2");
        look(1, 0, 10, 'h44, "R2");
        look(2, 0, 3, 'h56, "R3");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int w0 = $urandom_range(0, 3);
            int w1 = $urandom_range(0, 3);
            int lw = $urandom_range(0, 3);
            step($urandom_range(0, 2) == 0, $urandom_range(0, 3), w0, w0 * 256 + $urandom_range(0, 1), $urandom_range(0, 3),
                 $urandom_range(0, 2) == 0, $urandom_range(0, 3), w1, w1 * 256 + $urandom_range(0, 1), $urandom_range(0, 3),
                 $urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 3),
                 lw * 256 + $urandom_range(0, 1), "R3");
        end
        idle("R9");
        finish_run();
    end
endmodule